// File: doc/BRIEF.md
# Flash ECC Error Capture Unit

This unit sits on the read path of a two-bank flash array. Each raw read word is 72 bits wide: 64 data bits, 7 Hamming check bits and one overall parity bit. The unit decodes each word with a single-error-correct, double-error-detect code. It returns the corrected 64-bit data one cycle after the read strobe. It also keeps a small status block for software.

When the first error arrives, the status block records the double-word address and the bank of the failing read. It then holds that record until software clears every error flag by writing ones to the flag clear bits. A corrected error raises a maskable interrupt level. An uncorrectable error always produces a one-cycle non-maskable pulse.

Top module: `fecc_capture`

## Requirements
- R1: After reset the corrected-error flag, the uncorrectable-error flag, the captured address, the captured bank, the interrupt enable, `irq_o`, `nmi_o` and `rdata_valid_o` are all 0.
- R2: A read with `rd_valid` high sets `rdata_valid_o` at the next clock edge. With no bit in error, `rdata_o` equals `rd_word[63:0]` and neither flag is set. The raw word layout is as follows. Data bit i occupies code position p(i), where p(i) is the i-th integer from 3 upward that is not a power of two. Check bit j sits in `rd_word[64+j]` and is the XOR of the data bits whose position has bit j set. `rd_word[71]` gives the whole 72-bit word even parity.
- R3: When exactly one data bit of the word is inverted, `rdata_o` returns the original data and `corr_flag_o` is set.
- R4: When exactly one check bit (`rd_word[70:64]`) or the parity bit (`rd_word[71]`) is inverted, `rdata_o` equals `rd_word[63:0]` unchanged and `corr_flag_o` is set.
- R5: When exactly two bits anywhere in the word are inverted, `det_flag_o` is set, `corr_flag_o` is not set by that read, and `rdata_o` equals `rd_word[63:0]` with no correction.
- R6: `irq_o` is high exactly while `corr_flag_o` and the interrupt enable are both 1. A write with `csr_wr` high loads the interrupt enable from `csr_wdata[2]`.
- R7: `nmi_o` is high for exactly the one cycle after each read that has an uncorrectable error, whatever the interrupt enable holds.
- R8: On an error read while both flags are clear, the unit captures the read address with bits [2:0] forced to 0 in `cap_addr_o`, and `rd_bank` in `cap_bank_o`.
- R9: While either flag is set, later error reads change neither `cap_addr_o` nor `cap_bank_o`.
- R10: A write with `csr_wdata[0]`=1 clears `corr_flag_o`, and one with `csr_wdata[1]`=1 clears `det_flag_o`. A 0 in either bit leaves that flag unchanged. Once both flags are clear, the next error is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Read word strobe |
| rd_addr | input | 21 | Byte address of the read |
| rd_bank | input | 1 | Bank of the read |
| rd_word | input | 72 | Raw stored word (data, check bits, parity) |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 3 | [0] clear corrected flag, [1] clear uncorrectable flag, [2] interrupt enable |
| rdata_o | output | 64 | Corrected data |
| rdata_valid_o | output | 1 | Corrected data valid |
| corr_flag_o | output | 1 | Corrected-error flag |
| det_flag_o | output | 1 | Uncorrectable-error flag |
| cap_addr_o | output | 21 | Captured double-word address |
| cap_bank_o | output | 1 | Captured bank |
| irq_en_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Maskable corrected-error interrupt |
| nmi_o | output | 1 | Uncorrectable-error pulse |

## Verification
The corrected data, the valid bit, both flags, the captured fields and the NMI pulse all change at the first rising edge after the strobe. The bench drives on a falling edge and samples at the next falling edge, one half period after that rising edge. The NMI is checked low again one cycle later. `irq_o` follows the flag and the enable in the same cycle in which either changes, so the bench checks it right after each flag or enable update. Every single-bit flip position and every pair of flip positions are swept against a word encoder built into the bench.

// File: rtl/fecc_pkg.sv
package fecc_pkg;

   typedef enum logic [1:0] {
      EC_NONE   = 2'd0,
      EC_SINGLE = 2'd1,
      EC_DOUBLE = 2'd2
   } ecc_class_e;

   localparam int CSR_CLR_CORR = 0;
   localparam int CSR_CLR_DET  = 1;
   localparam int CSR_IRQ_EN   = 2;
   localparam int CSR_W        = 3;

   // number of Hamming check bits needed for dw data bits
   function automatic int ham_bits(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // code position of data bit i: the i-th non-power-of-two from 3 up
   function automatic int data_pos(input int i);
      int n;
      n = 0;
      for (int p = 3; p < 65536; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == i) return p;
            n++;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/fecc_syndrome.sv
module fecc_syndrome
   import fecc_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int HAM_W = ham_bits(DATA_W),
   localparam int CW_W  = DATA_W + HAM_W + 1
)(
   input  logic [CW_W-1:0]  raw_i,
   output logic [HAM_W-1:0] syn_o,
   output logic             par_err_o
);

   function automatic logic [DATA_W-1:0] ham_mask(input int j);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++)
         if (((data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
      return m;
   endfunction

   for (genvar j = 0; j < HAM_W; j++) begin : g_syn
      localparam logic [DATA_W-1:0] MASK = ham_mask(j);
      assign syn_o[j] = (^(raw_i[DATA_W-1:0] & MASK)) ^ raw_i[DATA_W+j];
   end

   assign par_err_o = ^raw_i;

endmodule

// File: rtl/fecc_fix.sv
module fecc_fix
   import fecc_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int HAM_W = ham_bits(DATA_W)
)(
   input  logic [DATA_W-1:0] data_i,
   input  logic [HAM_W-1:0]  syn_i,
   input  logic              par_err_i,
   output logic [DATA_W-1:0] data_o,
   output ecc_class_e        cls_o
);

   logic [DATA_W-1:0] flip;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
      assign flip[i] = par_err_i && (syn_i == POS);
   end

   assign data_o = data_i ^ flip;

   always_comb begin
      if (par_err_i)          cls_o = EC_SINGLE;
      else if (syn_i != '0)   cls_o = EC_DOUBLE;
      else                    cls_o = EC_NONE;
   end

endmodule

// File: rtl/fecc_status.sv
module fecc_status
   import fecc_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DW_LSB = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  ecc_class_e        ev_cls,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_bank,
   input  logic              csr_wr,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic              corr_flag_o,
   output logic              det_flag_o,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic              cap_bank_o,
   output logic              irq_en_o,
   output logic              irq_o,
   output logic              nmi_o
);

   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << DW_LSB) - 1);

   logic set_corr, set_det, clr_corr, clr_det, may_capture;

   assign set_corr    = ev_valid && (ev_cls == EC_SINGLE);
   assign set_det     = ev_valid && (ev_cls == EC_DOUBLE);
   assign clr_corr    = csr_wr && csr_wdata[CSR_CLR_CORR];
   assign clr_det     = csr_wr && csr_wdata[CSR_CLR_DET];
   assign may_capture = (set_corr || set_det) && !corr_flag_o && !det_flag_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_flag_o <= 1'b0;
         det_flag_o  <= 1'b0;
         cap_addr_o  <= '0;
         cap_bank_o  <= 1'b0;
         irq_en_o    <= 1'b0;
         nmi_o       <= 1'b0;
      end else begin
         corr_flag_o <= (corr_flag_o && !clr_corr) || set_corr;
         det_flag_o  <= (det_flag_o && !clr_det) || set_det;
         nmi_o       <= set_det;
         if (csr_wr) irq_en_o <= csr_wdata[CSR_IRQ_EN];
         if (may_capture) begin
            cap_addr_o <= ev_addr & ~LOW_MASK;
            cap_bank_o <= ev_bank;
         end
      end
   end

   assign irq_o = corr_flag_o && irq_en_o;

endmodule

// File: rtl/fecc_capture.sv
module fecc_capture
   import fecc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 21,
   parameter int DW_LSB = 3,
   localparam int HAM_W = ham_bits(DATA_W),
   localparam int CW_W  = DATA_W + HAM_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_bank,
   input  logic [CW_W-1:0]   rd_word,
   input  logic              csr_wr,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rdata_valid_o,
   output logic              corr_flag_o,
   output logic              det_flag_o,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic              cap_bank_o,
   output logic              irq_en_o,
   output logic              irq_o,
   output logic              nmi_o
);

   if (DATA_W < 4) begin : g_bad_data
      $error("fecc_capture: DATA_W must be at least 4");
   end
   if (DW_LSB < 0 || DW_LSB >= ADDR_W) begin : g_bad_lsb
      $error("fecc_capture: DW_LSB must lie inside ADDR_W");
   end

   logic [HAM_W-1:0]  syn;
   logic              par_err;
   logic [DATA_W-1:0] fixed;
   ecc_class_e        cls;

   fecc_syndrome #(.DATA_W(DATA_W)) u_syn (
      .raw_i     (rd_word),
      .syn_o     (syn),
      .par_err_o (par_err)
   );

   fecc_fix #(.DATA_W(DATA_W)) u_fix (
      .data_i    (rd_word[DATA_W-1:0]),
      .syn_i     (syn),
      .par_err_i (par_err),
      .data_o    (fixed),
      .cls_o     (cls)
   );

   fecc_status #(.ADDR_W(ADDR_W), .DW_LSB(DW_LSB)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_valid    (rd_valid),
      .ev_cls      (cls),
      .ev_addr     (rd_addr),
      .ev_bank     (rd_bank),
      .csr_wr      (csr_wr),
      .csr_wdata   (csr_wdata),
      .corr_flag_o (corr_flag_o),
      .det_flag_o  (det_flag_o),
      .cap_addr_o  (cap_addr_o),
      .cap_bank_o  (cap_bank_o),
      .irq_en_o    (irq_en_o),
      .irq_o       (irq_o),
      .nmi_o       (nmi_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o       <= '0;
         rdata_valid_o <= 1'b0;
      end else begin
         rdata_valid_o <= rd_valid;
         if (rd_valid) rdata_o <= fixed;
      end
   end

endmodule

// File: rtl/fecc_capture_chk.sv
module fecc_capture_chk
   import fecc_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DW_LSB = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic              csr_wr,
   input logic [CSR_W-1:0]  csr_wdata,
   input logic              rdata_valid_o,
   input logic              corr_flag_o,
   input logic              det_flag_o,
   input logic [ADDR_W-1:0] cap_addr_o,
   input logic              cap_bank_o,
   input logic              irq_en_o,
   input logic              irq_o,
   input logic              nmi_o
);

   // R2: data valid one cycle after strobe
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rdata_valid_o);

   // R6: maskable interrupt needs its enable
   p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en_o && corr_flag_o));

   // R7: every NMI pulse is accompanied by the uncorrectable flag and follows a read
   p_nmi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> (det_flag_o && $past(rd_valid)));

   // R8: captured address is always double-word aligned
   p_addr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_addr_o[DW_LSB-1:0] == '0);

   // R9: capture frozen while a flag is set
   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_flag_o || det_flag_o) |=> ($stable(cap_addr_o) && $stable(cap_bank_o)));

   // R10: a flag holds without a clear request
   p_hold_corr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_flag_o && !(csr_wr && csr_wdata[CSR_CLR_CORR])) |=> corr_flag_o);
   p_hold_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (det_flag_o && !(csr_wr && csr_wdata[CSR_CLR_DET])) |=> det_flag_o);

endmodule

bind fecc_capture fecc_capture_chk #(.ADDR_W(ADDR_W), .DW_LSB(DW_LSB)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_valid      (rd_valid),
   .csr_wr        (csr_wr),
   .csr_wdata     (csr_wdata),
   .rdata_valid_o (rdata_valid_o),
   .corr_flag_o   (corr_flag_o),
   .det_flag_o    (det_flag_o),
   .cap_addr_o    (cap_addr_o),
   .cap_bank_o    (cap_bank_o),
   .irq_en_o      (irq_en_o),
   .irq_o         (irq_o),
   .nmi_o         (nmi_o)
);

// File: tb/fecc_capture_test.sv
`timescale 1ns/1ps
module fecc_capture_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0;
   logic [20:0] rd_addr = '0;
   logic        rd_bank = 1'b0;
   logic [71:0] rd_word = '0;
   logic        csr_wr = 1'b0;
   logic [2:0]  csr_wdata = '0;
   logic [63:0] rdata_o;
   logic        rdata_valid_o, corr_flag_o, det_flag_o, cap_bank_o, irq_en_o, irq_o, nmi_o;
   logic [20:0] cap_addr_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic en = 1'b0;

   always #5 clk = ~clk;

   fecc_capture uut (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_bank(rd_bank), .rd_word(rd_word), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o), .corr_flag_o(corr_flag_o),
      .det_flag_o(det_flag_o), .cap_addr_o(cap_addr_o), .cap_bank_o(cap_bank_o),
      .irq_en_o(irq_en_o), .irq_o(irq_o), .nmi_o(nmi_o)
   );

   function automatic logic [71:0] encode(input logic [63:0] d);
      logic [127:0] cw;
      logic [71:0]  r;
      int n;
      cw = '0;
      n = 0;
      for (int p = 3; p < 72; p++)
         if ((p & (p - 1)) != 0) begin cw[p] = d[n]; n++; end
      r = '0;
      r[63:0] = d;
      for (int j = 0; j < 7; j++) begin
         logic c;
         c = 1'b0;
         for (int p = 3; p < 72; p++)
            if (((p & (p - 1)) != 0) && (((p >> j) & 1) != 0)) c = c ^ cw[p];
         r[64 + j] = c;
      end
      r[71] = ^r[70:0];
      return r;
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [20:0] a, input logic b, input logic [71:0] w);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a; rd_bank = b; rd_word = w;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic do_csr(input logic clr_c, input logic clr_d, input logic e);
      @(negedge clk);
      csr_wr = 1'b1; csr_wdata = {e, clr_d, clr_c};
      @(negedge clk);
      csr_wr = 1'b0;
      en = e;
   endtask

   function automatic logic [63:0] pattern(input int k);
      case (k)
         0: return 64'h0;
         1: return '1;
         2: return 64'hA5C3_0F96_5A3C_F069;
         default: return 64'h0123_4567_89AB_CDEF;
      endcase
   endfunction

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({corr_flag_o, det_flag_o, cap_bank_o, irq_en_o, irq_o, nmi_o, rdata_valid_o} == 0,
            "R1 flags", 64'({corr_flag_o, det_flag_o, irq_en_o, irq_o, nmi_o, rdata_valid_o}), 0);
      check(cap_addr_o == 0, "R1 cap_addr", 64'(cap_addr_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 4; k++) begin
         logic [63:0] d;
         logic [71:0] w;
         d = pattern(k);
         w = encode(d);
         do_read(21'(k * 8), 1'b0, w);
         check(rdata_valid_o, "R2 valid", 64'(rdata_valid_o), 1);
         check(rdata_o == d, "R2 clean data", rdata_o, d);
         check(!corr_flag_o && !det_flag_o, "R2 no flag", 64'({corr_flag_o, det_flag_o}), 0);
         for (int b = 0; b < 72; b++) begin
            do_read(21'(b), 1'b0, w ^ (72'd1 << b));
            if (b < 64) check(rdata_o == d, "R3 corrected data", rdata_o, d);
            else        check(rdata_o == d, "R4 check-bit data", rdata_o, d);
            check(corr_flag_o && !det_flag_o, b < 64 ? "R3 flag" : "R4 flag",
                  64'({corr_flag_o, det_flag_o}), 2);
            do_csr(1'b1, 1'b0, 1'b0);
            check(!corr_flag_o, "R10 clear corr", 64'(corr_flag_o), 0);
         end
      end

      begin
         logic [63:0] d;
         logic [71:0] w;
         d = pattern(2);
         w = encode(d);
         for (int i = 0; i < 72; i++)
            for (int j = i + 1; j < 72; j++) begin
               logic [71:0] bad;
               bad = w ^ (72'd1 << i) ^ (72'd1 << j);
               do_read(21'h0, 1'b0, bad);
               check(det_flag_o && !corr_flag_o, "R5 flags", 64'({corr_flag_o, det_flag_o}), 1);
               check(rdata_o == bad[63:0], "R5 data", rdata_o, bad[63:0]);
               check(nmi_o, "R7 pulse high", 64'(nmi_o), 1);
               do_csr(1'b0, 1'b1, 1'b0);
               check(!nmi_o, "R7 pulse one cycle", 64'(nmi_o), 0);
               check(!det_flag_o, "R10 clear det", 64'(det_flag_o), 0);
            end
      end

      begin
         logic [71:0] w;
         w = encode(pattern(3));
         do_csr(1'b1, 1'b1, 1'b0);
         // R8 capture
         do_read(21'h1ABCDF, 1'b1, w ^ 72'd1);
         check(cap_addr_o == 21'h1ABCD8, "R8 addr", 64'(cap_addr_o), 64'h1ABCD8);
         check(cap_bank_o == 1'b1, "R8 bank", 64'(cap_bank_o), 1);
         check(!irq_o, "R6 masked", 64'(irq_o), 0);
         do_csr(1'b0, 1'b0, 1'b1);
         check(irq_o && irq_en_o, "R6 enabled", 64'(irq_o), 1);
         // R9 freeze across double error
         do_read(21'h002347, 1'b0, w ^ 72'd3);
         check(cap_addr_o == 21'h1ABCD8 && cap_bank_o, "R9 frozen", 64'(cap_addr_o), 64'h1ABCD8);
         check(nmi_o && det_flag_o, "R7 nmi enabled", 64'(nmi_o), 1);
         do_csr(1'b1, 1'b0, 1'b1);
         check(!corr_flag_o && det_flag_o, "R10 selective clear", 64'({corr_flag_o, det_flag_o}), 1);
         check(!irq_o, "R6 irq drops", 64'(irq_o), 0);
         do_read(21'h000777, 1'b0, w ^ (72'd1 << 70));
         check(cap_addr_o == 21'h1ABCD8, "R9 still frozen", 64'(cap_addr_o), 64'h1ABCD8);
         do_csr(1'b1, 1'b1, 1'b0);
         check(!corr_flag_o && !det_flag_o && !irq_en_o, "R10 both clear",
               64'({corr_flag_o, det_flag_o, irq_en_o}), 0);
         do_read(21'h0F00FF, 1'b0, w ^ 72'h300);
         check(cap_addr_o == 21'h0F00F8 && !cap_bank_o, "R10 recapture", 64'(cap_addr_o), 64'h0F00F8);
         check(nmi_o, "R7 nmi masked enable", 64'(nmi_o), 1);
         do_read(21'h000010, 1'b1, w);
         check(!nmi_o, "R7 no nmi clean", 64'(nmi_o), 0);
         check(cap_addr_o == 21'h0F00F8, "R9 clean read no capture", 64'(cap_addr_o), 64'h0F00F8);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule